// File: doc/BRIEF.md
# Prioritized Result Routing Arbiter

This block gathers 16-bit conversion results from four producers: two on-chip converters, an external converter link and a companion-module return path. Each producer hands its word to a one-entry holding register. A fixed-priority picker chooses which held result is served. A tag decoder then sends that result to one of three places: the write port of one of six result FIFOs, a valid/ready streaming port (data, tag and destination go out together toward filter A, filter B or the reaction module), or nowhere, in which case a one-cycle discard pulse is raised.

A result from an on-chip converter may carry a time stamp. Such a result is stored as two back-to-back words in the same FIFO. The first word is held back until the FIFO reports room for two, so the pair always lands in adjacent slots. Once a result has been picked, the arbiter serves nothing else until that result is fully delivered.

Top module: `result_router`

## Requirements
- R1: After reset every `src_ready` bit is 1, and `fifo_wr_en`, `strm_valid` and `discard_pulse` are all 0.
- R2: A tag of 0 to 5 produces exactly one accepted write of the 16-bit data into the FIFO whose number equals the tag. A write counts as accepted when `fifo_wr_en[k]` and `fifo_ready[k]` are both 1 at a clock edge. At most one `fifo_wr_en` bit is ever set.
- R3: A tag of 9 or 10 produces exactly one streaming transfer carrying the data, the tag and the 2-bit destination unchanged. Those fields stay stable while `strm_ready` is 0.
- R4: A tag of 8 (null) or any of 6, 7 and 11 to 15 (reserved) raises `discard_pulse` once. The result causes no FIFO write and no streaming transfer, and its holding register is freed.
- R5: When several holding registers are full at once, they are served in the order source 0, source 1, source 2 (external link), source 3 (companion path).
- R6: While the selected result waits on a not-ready FIFO or streaming port, the outputs stay stable and no other source is served, even a higher-priority one that arrives during the wait.
- R7: A time-stamped result from source 0 or 1 (`src_ts_flag` set) is written only once `fifo_room2` of the target FIFO is 1. It is written as the result word, then the time-stamp word, accepted on two consecutive clock edges into the same FIFO.
- R8: `src_ts_flag` on sources 2 and 3 is ignored. Such a result is a single write of its data word.
- R9: `src_ready[i]` is 0 while holding register i is full. A word offered to a full holding register is not taken and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 4 | Per-source result offer |
| src_ready | output | 4 | Per-source holding register empty |
| src_data | input | 64 | Result data, 16 bits per source |
| src_tag | input | 16 | Message tag, 4 bits per source |
| src_dest | input | 8 | Destination field, 2 bits per source |
| src_ts_flag | input | 4 | Result carries a time stamp |
| src_ts | input | 64 | Time stamp, 16 bits per source |
| fifo_wr_en | output | 6 | One-hot FIFO write valid |
| fifo_wr_data | output | 16 | FIFO write data |
| fifo_ready | input | 6 | FIFO accepts a write this edge |
| fifo_room2 | input | 6 | FIFO has at least two free entries |
| strm_valid | output | 1 | Streaming transfer valid |
| strm_ready | input | 1 | Streaming sink ready |
| strm_data | output | 16 | Streaming data |
| strm_tag | output | 4 | Streaming tag |
| strm_dest | output | 2 | Streaming destination |
| discard_pulse | output | 1 | One-cycle pulse per dropped result |

## Verification
All four sources are loaded in the same cycle while the FIFOs are stalled. A picker with a wrong or re-evaluated priority would deliver the words out of order. A source 0 result is then sent while a source 1 result is stalled; a design that re-arbitrates would let it jump ahead or switch the data under a held write. A time-stamped pair is held with only one free slot; a design that ignores the two-slot check writes early or splits the pair, which shows up as non-adjacent acceptance cycles. Reserved tags, a time stamp on the external link and an offer to a full holding register are also covered. A wrong design would write where it should drop, write twice, or take a second word.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {ACT_DROP, ACT_FIFO, ACT_STREAM} rr_act_e;
  typedef enum logic [2:0] {
    S_IDLE, S_WR, S_PWAIT, S_P1, S_P2, S_STRM
  } rr_state_e;
endpackage

// File: rtl/rr_hold_slot.sv
module rr_hold_slot #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int DEST_W = 2,
  parameter bit TS_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DEST_W-1:0] in_dest,
  input  logic              in_ts_flag,
  input  logic [DATA_W-1:0] in_ts,
  input  logic              release_i,
  output logic              full,
  output logic [DATA_W-1:0] q_data,
  output logic [TAG_W-1:0]  q_tag,
  output logic [DEST_W-1:0] q_dest,
  output logic              q_ts_flag,
  output logic [DATA_W-1:0] q_ts
);
  logic flag_r;

  assign in_ready  = !full;
  assign q_ts_flag = flag_r & TS_EN;

  always_ff @(posedge clk) begin
    if (rst) begin
      full   <= 1'b0;
      flag_r <= 1'b0;
      q_data <= '0;
      q_tag  <= '0;
      q_dest <= '0;
      q_ts   <= '0;
    end else if (!full && in_valid) begin
      full   <= 1'b1;
      flag_r <= in_ts_flag;
      q_data <= in_data;
      q_tag  <= in_tag;
      q_dest <= in_dest;
      q_ts   <= in_ts;
    end else if (release_i) begin
      full <= 1'b0;
    end
  end

  assert_hold_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (full && !release_i) |=> (full && $stable(q_data) && $stable(q_tag)));
endmodule

// File: rtl/rr_prio_pick.sv
module rr_prio_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/rr_tag_decode.sv
module rr_tag_decode
  import rr_pkg::*;
#(
  parameter int TAG_W     = 4,
  parameter int NUM_FIFO  = 6,
  parameter int TAG_NULL  = 8,
  parameter int STRM_LO   = 9,
  parameter int STRM_HI   = 10,
  localparam int FIFO_W   = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
  input  logic [TAG_W-1:0]  tag,
  output rr_act_e           act,
  output logic [FIFO_W-1:0] fifo_idx
);
  always_comb begin
    fifo_idx = tag[FIFO_W-1:0];
    if (int'(tag) < NUM_FIFO && int'(tag) != TAG_NULL)
      act = ACT_FIFO;
    else if (int'(tag) >= STRM_LO && int'(tag) <= STRM_HI)
      act = ACT_STREAM;
    else
      act = ACT_DROP;
  end
endmodule

// File: rtl/result_router.sv
module result_router
  import rr_pkg::*;
#(
  parameter int NUM_SRC    = 4,
  parameter int TS_SRC_CNT = 2,
  parameter int NUM_FIFO   = 6,
  parameter int DATA_W     = 16,
  parameter int TAG_W      = 4,
  parameter int DEST_W     = 2,
  parameter int TAG_NULL   = 8,
  parameter int STRM_LO    = 9,
  parameter int STRM_HI    = 10,
  localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int FIFO_W    = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        src_valid,
  output logic [NUM_SRC-1:0]        src_ready,
  input  logic [NUM_SRC*DATA_W-1:0] src_data,
  input  logic [NUM_SRC*TAG_W-1:0]  src_tag,
  input  logic [NUM_SRC*DEST_W-1:0] src_dest,
  input  logic [NUM_SRC-1:0]        src_ts_flag,
  input  logic [NUM_SRC*DATA_W-1:0] src_ts,
  output logic [NUM_FIFO-1:0]       fifo_wr_en,
  output logic [DATA_W-1:0]         fifo_wr_data,
  input  logic [NUM_FIFO-1:0]       fifo_ready,
  input  logic [NUM_FIFO-1:0]       fifo_room2,
  output logic                      strm_valid,
  input  logic                      strm_ready,
  output logic [DATA_W-1:0]         strm_data,
  output logic [TAG_W-1:0]          strm_tag,
  output logic [DEST_W-1:0]         strm_dest,
  output logic                      discard_pulse
);
  logic [NUM_SRC-1:0] pend, rel, h_tsf;
  logic [DATA_W-1:0]  h_data [NUM_SRC];
  logic [DATA_W-1:0]  h_ts   [NUM_SRC];
  logic [TAG_W-1:0]   h_tag  [NUM_SRC];
  logic [DEST_W-1:0]  h_dest [NUM_SRC];

  // one holding register per producer; time stamps only on on-chip ones
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    rr_hold_slot #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .DEST_W(DEST_W),
      .TS_EN(i < TS_SRC_CNT)
    ) u_slot (
      .clk(clk), .rst(rst),
      .in_valid(src_valid[i]), .in_ready(src_ready[i]),
      .in_data(src_data[i*DATA_W +: DATA_W]),
      .in_tag(src_tag[i*TAG_W +: TAG_W]),
      .in_dest(src_dest[i*DEST_W +: DEST_W]),
      .in_ts_flag(src_ts_flag[i]),
      .in_ts(src_ts[i*DATA_W +: DATA_W]),
      .release_i(rel[i]), .full(pend[i]),
      .q_data(h_data[i]), .q_tag(h_tag[i]), .q_dest(h_dest[i]),
      .q_ts_flag(h_tsf[i]), .q_ts(h_ts[i])
    );
  end

  logic              any;
  logic [SRC_W-1:0]  gidx;
  rr_prio_pick #(.N(NUM_SRC)) u_pick (.req(pend), .any(any), .idx(gidx));

  rr_act_e           act;
  logic [FIFO_W-1:0] fidx;
  rr_tag_decode #(
    .TAG_W(TAG_W), .NUM_FIFO(NUM_FIFO), .TAG_NULL(TAG_NULL),
    .STRM_LO(STRM_LO), .STRM_HI(STRM_HI)
  ) u_dec (.tag(h_tag[gidx]), .act(act), .fifo_idx(fidx));

  rr_state_e         st;
  logic [SRC_W-1:0]  cur_src;
  logic [FIFO_W-1:0] cur_fifo;
  logic [DATA_W-1:0] cur_ts;
  logic              wr_go, done_ev, drop_now;

  assign wr_go    = |(fifo_wr_en & fifo_ready);
  assign done_ev  = ((st == S_WR || st == S_P2) && wr_go) ||
                    (st == S_STRM && strm_ready);
  assign drop_now = (st == S_IDLE) && any && (act == ACT_DROP);

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      rel[i] = (done_ev && cur_src == SRC_W'(i)) ||
               (drop_now && gidx == SRC_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      cur_src       <= '0;
      cur_fifo      <= '0;
      cur_ts        <= '0;
      fifo_wr_en    <= '0;
      fifo_wr_data  <= '0;
      strm_valid    <= 1'b0;
      strm_data     <= '0;
      strm_tag      <= '0;
      strm_dest     <= '0;
      discard_pulse <= 1'b0;
    end else begin
      discard_pulse <= 1'b0;
      unique case (st)
        S_IDLE: if (any) begin
          cur_src  <= gidx;
          cur_fifo <= fidx;
          cur_ts   <= h_ts[gidx];
          case (act)
            ACT_DROP: discard_pulse <= 1'b1;
            ACT_FIFO: begin
              fifo_wr_data <= h_data[gidx];
              if (!h_tsf[gidx]) begin
                fifo_wr_en <= NUM_FIFO'(1) << fidx;
                st         <= S_WR;
              end else if (fifo_room2[fidx]) begin
                fifo_wr_en <= NUM_FIFO'(1) << fidx;
                st         <= S_P1;
              end else begin
                st <= S_PWAIT;
              end
            end
            default: begin
              strm_valid <= 1'b1;
              strm_data  <= h_data[gidx];
              strm_tag   <= h_tag[gidx];
              strm_dest  <= h_dest[gidx];
              st         <= S_STRM;
            end
          endcase
        end
        S_WR: if (wr_go) begin
          fifo_wr_en <= '0;
          st         <= S_IDLE;
        end
        S_PWAIT: if (fifo_room2[cur_fifo]) begin
          fifo_wr_en <= NUM_FIFO'(1) << cur_fifo;
          st         <= S_P1;
        end
        S_P1: if (wr_go) begin
          fifo_wr_data <= cur_ts;
          st           <= S_P2;
        end
        S_P2: if (wr_go) begin
          fifo_wr_en <= '0;
          st         <= S_IDLE;
        end
        S_STRM: if (strm_ready) begin
          strm_valid <= 1'b0;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fifo_wr_en == '0 && !strm_valid && !discard_pulse));
  assert_wr_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fifo_wr_en));
  assert_strm_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (strm_valid && !strm_ready) |=>
      (strm_valid && $stable(strm_data) && $stable(strm_tag) && $stable(strm_dest)));
  assert_drop_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    discard_pulse |-> (fifo_wr_en == '0 && !strm_valid));
  assert_prio_first_R5: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && pend[0]) |=> (cur_src == '0));
  assert_wr_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (|fifo_wr_en && !wr_go) |=> ($stable(fifo_wr_en) && $stable(fifo_wr_data)));
  assert_pair_adjacent_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_P1 && wr_go) |=> (fifo_wr_en == $past(fifo_wr_en)));
endmodule

// File: tb/result_router_test.sv
module result_router_test;
  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic [3:0]  src_valid = '0, src_ready, src_ts_flag = '0;
  logic [63:0] src_data = '0, src_ts = '0;
  logic [15:0] src_tag = '0;
  logic [7:0]  src_dest = '0;
  logic [5:0]  fifo_wr_en, fifo_ready = '1, fifo_room2 = '1;
  logic [15:0] fifo_wr_data, strm_data;
  logic        strm_valid, strm_ready = 1'b1, discard_pulse;
  logic [3:0]  strm_tag;
  logic [1:0]  strm_dest;

  result_router uut (.*);

  int total = 0, bad = 0, cyc = 0, ev_cnt = 0;
  int ev_kind [0:255];
  int ev_idx  [0:255];
  int ev_data [0:255];
  int ev_tag  [0:255];
  int ev_dest [0:255];
  int ev_cyc  [0:255];

  always @(posedge clk) cyc <= cyc + 1;

  // event log: 1 = FIFO word, 2 = stream transfer, 3 = discard
  always @(negedge clk) if (!rst) begin
    for (int k = 0; k < 6; k++)
      if (fifo_wr_en[k] && fifo_ready[k]) begin
        ev_kind[ev_cnt] = 1; ev_idx[ev_cnt] = k; ev_data[ev_cnt] = fifo_wr_data;
        ev_tag[ev_cnt] = 0; ev_dest[ev_cnt] = 0; ev_cyc[ev_cnt] = cyc;
        ev_cnt++;
      end
    if (strm_valid && strm_ready) begin
      ev_kind[ev_cnt] = 2; ev_idx[ev_cnt] = 0; ev_data[ev_cnt] = strm_data;
      ev_tag[ev_cnt] = strm_tag; ev_dest[ev_cnt] = strm_dest; ev_cyc[ev_cnt] = cyc;
      ev_cnt++;
    end
    if (discard_pulse) begin
      ev_kind[ev_cnt] = 3; ev_idx[ev_cnt] = 0; ev_data[ev_cnt] = 0;
      ev_tag[ev_cnt] = 0; ev_dest[ev_cnt] = 0; ev_cyc[ev_cnt] = cyc;
      ev_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic offer(input int s, input int tag, input int dest, input bit tsf,
                       input int data, input int ts);
    src_valid[s] = 1'b1;
    src_tag[s*4 +: 4]   = 4'(tag);
    src_dest[s*2 +: 2]  = 2'(dest);
    src_ts_flag[s]      = tsf;
    src_data[s*16 +: 16] = 16'(data);
    src_ts[s*16 +: 16]   = 16'(ts);
  endtask

  task automatic send(input int s, input int tag, input int dest, input bit tsf,
                      input int data, input int ts);
    offer(s, tag, dest, tsf, data, ts);
    tick(1);
    src_valid = '0;
  endtask

  // src(2) tag(4) dest(2) tsf(1) data(16) ts(16) kind(2) words(2)
  localparam logic [44:0] VEC [0:11] = '{
    {2'd0, 4'd0,  2'd0, 1'b0, 16'h1111, 16'h0000, 2'd1, 2'd1},
    {2'd1, 4'd5,  2'd1, 1'b0, 16'h2222, 16'h0000, 2'd1, 2'd1},
    {2'd2, 4'd3,  2'd1, 1'b0, 16'h3333, 16'h0000, 2'd1, 2'd1},
    {2'd3, 4'd9,  2'd0, 1'b0, 16'h4444, 16'h0000, 2'd2, 2'd1},
    {2'd1, 4'd10, 2'd2, 1'b0, 16'h5555, 16'h0000, 2'd2, 2'd1},
    {2'd0, 4'd8,  2'd0, 1'b0, 16'h6666, 16'h0000, 2'd3, 2'd1},
    {2'd2, 4'd7,  2'd3, 1'b0, 16'h7777, 16'h0000, 2'd3, 2'd1},
    {2'd3, 4'd15, 2'd0, 1'b0, 16'h8888, 16'h0000, 2'd3, 2'd1},
    {2'd1, 4'd4,  2'd0, 1'b1, 16'h9999, 16'hBEEF, 2'd1, 2'd2},
    {2'd3, 4'd2,  2'd0, 1'b1, 16'hAAAA, 16'hCAFE, 2'd1, 2'd1},
    {2'd0, 4'd6,  2'd0, 1'b0, 16'hBBBB, 16'h0000, 2'd3, 2'd1},
    {2'd1, 4'd11, 2'd1, 1'b0, 16'hCCCC, 16'h0000, 2'd3, 2'd1}
  };

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL R1-watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    tick(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(src_ready == 4'hF, "R1", "src_ready", src_ready, 4'hF);
    chk(fifo_wr_en == 0 && !strm_valid && !discard_pulse, "R1", "outputs idle",
        {fifo_wr_en, strm_valid, discard_pulse}, 0);
    tick(1);

    // table walk: R2 R3 R4 R8
    foreach (VEC[v]) begin
      int s, tag, dest, data, ts, kind, words;
      bit tsf;
      {s, tag, dest, tsf, data, ts, kind, words} = {30'd0, VEC[v][44:43], 28'd0,
        VEC[v][42:39], 30'd0, VEC[v][38:37], VEC[v][36], 16'd0, VEC[v][35:20],
        16'd0, VEC[v][19:4], 30'd0, VEC[v][3:2], 30'd0, VEC[v][1:0]};
      base = ev_cnt;
      send(s, tag, dest, tsf, data, ts);
      tick(10);
      chk(ev_cnt - base == words, kind == 1 ? (s >= 2 && tsf ? "R8" : "R2") :
          kind == 2 ? "R3" : "R4", "event count", ev_cnt - base, words);
      if (ev_cnt - base == words) begin
        chk(ev_kind[base] == kind, kind == 1 ? "R2" : kind == 2 ? "R3" : "R4",
            "event kind", ev_kind[base], kind);
        if (kind == 1)
          chk(ev_idx[base] == tag && ev_data[base] == data, "R2", "fifo/data",
              {ev_idx[base][7:0], ev_data[base][15:0]}, {tag[7:0], data[15:0]});
        if (kind == 2)
          chk(ev_data[base] == data && ev_tag[base] == tag && ev_dest[base] == dest,
              "R3", "stream fields", {ev_data[base][15:0], ev_tag[base][3:0], ev_dest[base][1:0]},
              {data[15:0], tag[3:0], dest[1:0]});
        if (words == 2)
          chk(ev_data[base+1] == ts && ev_idx[base+1] == tag &&
              ev_cyc[base+1] == ev_cyc[base] + 1, "R7", "stamp beat",
              ev_data[base+1], ts);
      end
    end

    // R5 priority: load all four while FIFOs stalled
    fifo_ready = '0;
    base = ev_cnt;
    offer(3, 3, 0, 0, 16'hD003, 0);
    offer(2, 2, 0, 0, 16'hD002, 0);
    offer(1, 1, 0, 0, 16'hD001, 0);
    offer(0, 0, 0, 0, 16'hD000, 0);
    tick(1);
    src_valid = '0;
    tick(4);
    fifo_ready = '1;
    tick(20);
    chk(ev_cnt - base == 4, "R5", "count", ev_cnt - base, 4);
    for (int j = 0; j < 4; j++)
      chk(ev_data[base+j] == (16'hD000 + j) && ev_idx[base+j] == j, "R5", "order",
          ev_data[base+j], 16'hD000 + j);

    // R6 stall: source 1 stalled, source 0 arrives during the wait
    fifo_ready = '0;
    base = ev_cnt;
    send(1, 2, 0, 0, 16'hA1A1, 0);
    tick(3);
    send(0, 3, 0, 0, 16'hB0B0, 0);
    tick(3);
    @(negedge clk);
    chk(fifo_wr_en == 6'b000100 && fifo_wr_data == 16'hA1A1, "R6", "held write",
        {fifo_wr_en, fifo_wr_data}, {6'b000100, 16'hA1A1});
    tick(1);
    fifo_ready = '1;
    tick(10);
    chk(ev_cnt - base == 2 && ev_data[base] == 16'hA1A1 && ev_data[base+1] == 16'hB0B0,
        "R6", "stalled first", ev_data[base], 16'hA1A1);

    // R7 pair waits for two free entries
    fifo_room2 = '0;
    base = ev_cnt;
    send(0, 1, 0, 1, 16'hC1C1, 16'hD1D1);
    tick(6);
    chk(ev_cnt == base && fifo_wr_en == 0, "R7", "no early write", ev_cnt - base, 0);
    fifo_room2 = '1;
    tick(10);
    chk(ev_cnt - base == 2, "R7", "pair count", ev_cnt - base, 2);
    chk(ev_data[base] == 16'hC1C1 && ev_data[base+1] == 16'hD1D1 &&
        ev_idx[base] == 1 && ev_idx[base+1] == 1 && ev_cyc[base+1] == ev_cyc[base] + 1,
        "R7", "pair adjacent", ev_data[base+1], 16'hD1D1);

    // R9 holding register full: second offer not taken
    strm_ready = 1'b0;
    base = ev_cnt;
    send(2, 9, 1, 0, 16'hE1E1, 0);
    tick(3);
    @(negedge clk);
    chk(src_ready[2] == 1'b0, "R9", "ready low when full", src_ready[2], 0);
    chk(strm_valid && strm_data == 16'hE1E1, "R3", "stream held", strm_data, 16'hE1E1);
    tick(1);
    send(2, 0, 0, 0, 16'hE2E2, 0);
    tick(2);
    strm_ready = 1'b1;
    tick(10);
    chk(ev_cnt - base == 1 && ev_data[base] == 16'hE1E1, "R9", "only first word",
        ev_cnt - base, 1);
    @(negedge clk);
    chk(src_ready == 4'hF, "R9", "ready after drain", src_ready, 4'hF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule